// File: doc/BRIEF.md
# Regulator Start-Up and Overcurrent Latch-Off Sequencer

This block is the digital sequencer that starts a multiphase core regulator and shuts it down after a lasting overload. Two internal counters, in millivolt units, stand in for the voltages on two timing capacitors. The soft-start ramp paces the output on the way up. The good-delay ramp spaces out the clock-enable event and the final power-good flag. Each ramp moves by a fixed step per clock to model its charge or discharge current.

After supply and enable become valid, the sequencer turns bias on and waits out a fixed reset interval. It then waits out a phase-detection interval, and only then lets the soft-start ramp climb. Once that ramp passes the clock-enable level with the output inside its window, clock-enable (active low) asserts. From then on the soft-start ramp is driven quickly to its clamp, and the good-delay ramp charges toward its termination level.

A current-limit or power-good fault starts a slow soft-start discharge. If the fault clears in time, the regulator recovers. If the ramp falls below the latch level first, the controller shuts down and stays down until supply or enable is cycled. All pins are plain control and status levels. Nothing streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `vrseq_top`

## Requirements
- R1: While `uvlo` is high or `en` is low, `bias_en`, `pwr_good` and `shutdown` are 0 and `clk_en_n` is 1 in that same cycle. On the next clock edge the state becomes OFF (code 0), and `ss_mv` and `pgd_mv` become 0.
- R2: From OFF with supply valid, the state goes to RESET (code 1) for `RESET_CYC` cycles, then to DETECT (code 2) for `PHASE_CYC` cycles, then to SOFTSTART (code 3). `bias_en` is 1 in every state except OFF and LATCHED (code 6).
- R3: In SOFTSTART, `ss_mv` rises by `SS_UP_MV` per cycle and saturates at `CLAMP_MV`. `pgd_mv` stays 0 and `clk_en_n` stays 1.
- R4: SOFTSTART moves to ACTIVE (code 4) on the first edge where `ss_mv >= CLKEN_MV` and `in_window` is 1, and it waits there as long as `in_window` is 0. `clk_en_n` is 0 in ACTIVE and in DISCHARGE (code 5).
- R5: In ACTIVE, `ss_mv` rises by `SS_FAST_MV` per cycle and `pgd_mv` rises by `PGD_UP_MV` per cycle. Both saturate at `CLAMP_MV`.
- R6: `pwr_good` is 1 exactly when the state is ACTIVE, `pgd_mv >= PGD_DONE_MV` and `in_window` is 1. It follows `in_window` in the same cycle.
- R7: In ACTIVE, `ilim` or `pg_fault` moves the state to DISCHARGE. In DISCHARGE, `ss_mv` falls by `SS_DN_MV` per cycle with a floor of 0, and `pgd_mv` holds its value. Faults have no effect in OFF, RESET, DETECT, SOFTSTART or LATCHED.
- R8: In DISCHARGE, a cycle with both faults low returns the state to ACTIVE. This return takes priority over latching.
- R9: In DISCHARGE, a fault together with `ss_mv < LATCH_MV` moves the state to LATCHED. In LATCHED, `shutdown` is 1, `bias_en` is 0, `clk_en_n` is 1, and both ramps clear to 0.
- R10: LATCHED is held while supply stays valid, whatever the fault inputs do. Raising `uvlo` or lowering `en` for one cycle returns the state to OFF, and a new start then begins at RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo | input | 1 | Supply below undervoltage threshold |
| en | input | 1 | Enable pin |
| ilim | input | 1 | Current-limit flag |
| pg_fault | input | 1 | Power-good fault flag |
| in_window | input | 1 | Output voltage inside its good window |
| bias_en | output | 1 | Internal bias enable |
| ss_charge | output | 1 | Soft-start charge command |
| ss_discharge | output | 1 | Soft-start discharge command |
| clk_en_n | output | 1 | Clock enable, active low |
| pgd_charge | output | 1 | Good-delay charge command |
| pwr_good | output | 1 | Final power-good flag |
| shutdown | output | 1 | Latched-off indication |
| ss_mv | output | MV_W | Soft-start ramp level, mV |
| pgd_mv | output | MV_W | Good-delay ramp level, mV |
| state_dbg | output | 3 | Current state code |

## Verification
The bench builds the block with a five-cycle reset interval, a three-cycle detection interval, and coarse ramp steps: 50 mV soft-start charge, 200 mV fast charge, 25 mV discharge and 100 mV good-delay charge. With these values a full start-up takes well under a hundred cycles. The 1250 mV gap between clamp and latch level drains in about fifty cycles. Within a short run the bench can therefore reach saturation at the clamp, a stall while the window is out, a fault that recovers before the latch level, a fault that latches, and release of the latch through both enable and undervoltage.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_RESET     = 3'd1,
    ST_DETECT    = 3'd2,
    ST_SOFTSTART = 3'd3,
    ST_ACTIVE    = 3'd4,
    ST_DISCHARGE = 3'd5,
    ST_LATCHED   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/vrseq_ramp.sv
// Saturating up/down level counter standing in for a capacitor voltage.
module vrseq_ramp #(
  parameter int W    = 12,
  parameter int MAXV = 2900
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         up,
  input  logic         dn,
  input  logic [W-1:0] step,
  output logic [W-1:0] q
);
  localparam logic [W:0] LIMIT = (W+1)'(MAXV);

  logic [W:0] sum;
  assign sum = {1'b0, q} + {1'b0, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (up) begin
      if (sum > LIMIT) q <= LIMIT[W-1:0];
      else             q <= sum[W-1:0];
    end else if (dn) begin
      if (q > step) q <= q - step;
      else          q <= '0;
    end
  end
endmodule

// File: rtl/vrseq_timer.sv
// Interval counter for the reset and phase-detection waits.
module vrseq_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vrseq_fsm.sv
// Sequencing state register and next-state decision.
module vrseq_fsm
  import vrseq_pkg::*;
#(
  parameter int MV_W      = 12,
  parameter int TW        = 13,
  parameter int RESET_CYC = 5500,
  parameter int PHASE_CYC = 100,
  parameter int CLKEN_MV  = 1700,
  parameter int LATCH_MV  = 1650
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            fault,
  input  logic            in_window,
  input  logic [MV_W-1:0] ss_mv,
  input  logic [TW-1:0]   tmr,
  output seq_state_e      state,
  output logic            tmr_clr
);
  localparam logic [TW-1:0]   RESET_LAST = TW'(RESET_CYC - 1);
  localparam logic [TW-1:0]   PHASE_LAST = TW'(PHASE_CYC - 1);
  localparam logic [MV_W-1:0] CLKEN_LVL  = MV_W'(CLKEN_MV);
  localparam logic [MV_W-1:0] LATCH_LVL  = MV_W'(LATCH_MV);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    if (!valid) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:       nxt = ST_RESET;
        ST_RESET:     if (tmr == RESET_LAST) nxt = ST_DETECT;
        ST_DETECT:    if (tmr == PHASE_LAST) nxt = ST_SOFTSTART;
        ST_SOFTSTART: if (ss_mv >= CLKEN_LVL && in_window) nxt = ST_ACTIVE;
        ST_ACTIVE:    if (fault) nxt = ST_DISCHARGE;
        ST_DISCHARGE: begin
          if (!fault)                 nxt = ST_ACTIVE;
          else if (ss_mv < LATCH_LVL) nxt = ST_LATCHED;
        end
        ST_LATCHED:   nxt = ST_LATCHED;
        default:      nxt = ST_OFF;
      endcase
    end
  end

  assign tmr_clr = (nxt != state) || !(state == ST_RESET || state == ST_DETECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end
endmodule

// File: rtl/vrseq_top.sv
module vrseq_top
  import vrseq_pkg::*;
#(
  parameter int MV_W        = 12,
  parameter int RESET_CYC   = 5500,
  parameter int PHASE_CYC   = 100,
  parameter int SS_UP_MV    = 1,
  parameter int SS_FAST_MV  = 20,
  parameter int SS_DN_MV    = 1,
  parameter int PGD_UP_MV   = 1,
  parameter int CLKEN_MV    = 1700,
  parameter int CLAMP_MV    = 2900,
  parameter int LATCH_MV    = 1650,
  parameter int PGD_DONE_MV = 2900
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uvlo,
  input  logic            en,
  input  logic            ilim,
  input  logic            pg_fault,
  input  logic            in_window,
  output logic            bias_en,
  output logic            ss_charge,
  output logic            ss_discharge,
  output logic            clk_en_n,
  output logic            pgd_charge,
  output logic            pwr_good,
  output logic            shutdown,
  output logic [MV_W-1:0] ss_mv,
  output logic [MV_W-1:0] pgd_mv,
  output logic [2:0]      state_dbg
);
  localparam int TMAX = (RESET_CYC > PHASE_CYC) ? RESET_CYC : PHASE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [MV_W-1:0] PGD_DONE_LVL = MV_W'(PGD_DONE_MV);

  seq_state_e      st;
  logic            valid, fault, tmr_clr;
  logic [TW-1:0]   tmr;
  logic            ss_clr, ss_up, ss_dn, pgd_clr, pgd_up;
  logic [MV_W-1:0] ss_step;
  logic            run_on;

  assign valid  = !uvlo && en;
  assign fault  = ilim || pg_fault;
  assign run_on = (st == ST_ACTIVE) || (st == ST_DISCHARGE);

  vrseq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr)
  );

  vrseq_fsm #(
    .MV_W(MV_W), .TW(TW), .RESET_CYC(RESET_CYC), .PHASE_CYC(PHASE_CYC),
    .CLKEN_MV(CLKEN_MV), .LATCH_MV(LATCH_MV)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .valid(valid), .fault(fault),
    .in_window(in_window), .ss_mv(ss_mv), .tmr(tmr),
    .state(st), .tmr_clr(tmr_clr)
  );

  // Ramp commands derived from the present state
  always_comb begin
    ss_clr  = !valid || !(st == ST_SOFTSTART || run_on);
    ss_up   = (st == ST_SOFTSTART) || (st == ST_ACTIVE);
    ss_dn   = (st == ST_DISCHARGE);
    pgd_clr = !valid || !run_on;
    pgd_up  = (st == ST_ACTIVE);
    unique case (st)
      ST_ACTIVE:    ss_step = MV_W'(SS_FAST_MV);
      ST_DISCHARGE: ss_step = MV_W'(SS_DN_MV);
      default:      ss_step = MV_W'(SS_UP_MV);
    endcase
  end

  vrseq_ramp #(.W(MV_W), .MAXV(CLAMP_MV)) u_ss (
    .clk(clk), .rst_n(rst_n), .clr(ss_clr), .up(ss_up), .dn(ss_dn),
    .step(ss_step), .q(ss_mv)
  );

  vrseq_ramp #(.W(MV_W), .MAXV(CLAMP_MV)) u_pgd (
    .clk(clk), .rst_n(rst_n), .clr(pgd_clr), .up(pgd_up), .dn(1'b0),
    .step(MV_W'(PGD_UP_MV)), .q(pgd_mv)
  );

  assign bias_en      = valid && !(st == ST_OFF || st == ST_LATCHED);
  assign ss_charge    = ss_up && !ss_clr;
  assign ss_discharge = ss_dn && !ss_clr;
  assign pgd_charge   = pgd_up && !pgd_clr;
  assign clk_en_n     = !(valid && run_on);
  assign pwr_good     = valid && (st == ST_ACTIVE) && (pgd_mv >= PGD_DONE_LVL) && in_window;
  assign shutdown     = valid && (st == ST_LATCHED);
  assign state_dbg    = st;
endmodule

// File: rtl/vrseq_checker.sv
module vrseq_checker #(
  parameter int MV_W     = 12,
  parameter int CLAMP_MV = 2900
) (
  input logic            clk,
  input logic            rst_n,
  input logic            uvlo,
  input logic            en,
  input logic            in_window,
  input logic            bias_en,
  input logic            clk_en_n,
  input logic            pwr_good,
  input logic            shutdown,
  input logic [MV_W-1:0] ss_mv,
  input logic [MV_W-1:0] pgd_mv,
  input logic [2:0]      state_dbg
);
  p_off_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo || !en) |=> (ss_mv == '0 && pgd_mv == '0 && state_dbg == 3'd0));

  p_off_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo || !en) |-> (!bias_en && !pwr_good && clk_en_n && !shutdown));

  p_detect_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg == 3'd2) |-> ($past(state_dbg) == 3'd1 || $past(state_dbg) == 3'd2));

  p_pgd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg == 3'd3) |-> (pgd_mv == '0 && clk_en_n));

  p_ss_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_mv <= MV_W'(CLAMP_MV) && pgd_mv <= MV_W'(CLAMP_MV)));

  p_pg_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> (in_window && !clk_en_n && state_dbg == 3'd4));

  p_disch_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg == 3'd5) |=> (ss_mv <= $past(ss_mv)));

  p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!bias_en && clk_en_n && !pwr_good));

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg == 3'd6 && !uvlo && en) |=> (state_dbg == 3'd6));
endmodule

bind vrseq_top vrseq_checker #(.MV_W(MV_W), .CLAMP_MV(CLAMP_MV)) u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .en(en), .in_window(in_window),
  .bias_en(bias_en), .clk_en_n(clk_en_n), .pwr_good(pwr_good),
  .shutdown(shutdown), .ss_mv(ss_mv), .pgd_mv(pgd_mv), .state_dbg(state_dbg)
);

// File: tb/vrseq_top_test.sv
`timescale 1ns/1ps
module vrseq_top_test;
  localparam int W = 12;
  localparam int RC = 5, PC = 3;
  localparam int UP = 50, FAST = 200, DN = 25, PUP = 100;
  localparam int CLKEN = 1700, CLAMP = 2900, LATCH = 1650, DONE = 2900;

  logic clk = 0, rst_n = 0;
  logic uvlo = 1, en = 0, ilim = 0, pg_fault = 0, in_window = 0;
  logic bias_en, ss_charge, ss_discharge, clk_en_n, pgd_charge, pwr_good, shutdown;
  logic [W-1:0] ss_mv, pgd_mv;
  logic [2:0] state_dbg;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vrseq_top #(
    .MV_W(W), .RESET_CYC(RC), .PHASE_CYC(PC), .SS_UP_MV(UP), .SS_FAST_MV(FAST),
    .SS_DN_MV(DN), .PGD_UP_MV(PUP), .CLKEN_MV(CLKEN), .CLAMP_MV(CLAMP),
    .LATCH_MV(LATCH), .PGD_DONE_MV(DONE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .en(en), .ilim(ilim),
    .pg_fault(pg_fault), .in_window(in_window), .bias_en(bias_en),
    .ss_charge(ss_charge), .ss_discharge(ss_discharge), .clk_en_n(clk_en_n),
    .pgd_charge(pgd_charge), .pwr_good(pwr_good), .shutdown(shutdown),
    .ss_mv(ss_mv), .pgd_mv(pgd_mv), .state_dbg(state_dbg)
  );

  // Behavioural reference: state code, interval count, two ramp levels
  int m_st = 0, m_t = 0, m_ss = 0, m_pg = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_ss = 0; m_pg = 0;
    end else begin
      bit ok, flt;
      int nx;
      ok  = !uvlo && en;
      flt = ilim || pg_fault;
      nx  = m_st;
      if (!ok) nx = 0;
      else if (m_st == 0) nx = 1;
      else if (m_st == 1) begin if (m_t + 1 >= RC) nx = 2; end
      else if (m_st == 2) begin if (m_t + 1 >= PC) nx = 3; end
      else if (m_st == 3) begin if (m_ss >= CLKEN && in_window) nx = 4; end
      else if (m_st == 4) begin if (flt) nx = 5; end
      else if (m_st == 5) begin
        if (!flt) nx = 4;
        else if (m_ss < LATCH) nx = 6;
      end
      // ramps move according to the state being left
      if (!ok || m_st < 3 || m_st == 6) m_ss = 0;
      else if (m_st == 3) m_ss = (m_ss + UP > CLAMP) ? CLAMP : m_ss + UP;
      else if (m_st == 4) m_ss = (m_ss + FAST > CLAMP) ? CLAMP : m_ss + FAST;
      else m_ss = (m_ss > DN) ? m_ss - DN : 0;
      if (!ok || !(m_st == 4 || m_st == 5)) m_pg = 0;
      else if (m_st == 4) m_pg = (m_pg + PUP > CLAMP) ? CLAMP : m_pg + PUP;
      m_t = (nx == m_st && (m_st == 1 || m_st == 2)) ? m_t + 1 : 0;
      m_st = nx;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ok;
      ok = !uvlo && en;
      chk("R2 state", state_dbg, m_st);
      chk("R3 ss level", ss_mv, m_ss);
      chk("R5 pgd level", pgd_mv, m_pg);
      chk("R1 bias_en", bias_en, ok && !(m_st == 0 || m_st == 6));
      chk("R4 clk_en_n", clk_en_n, !(ok && (m_st == 4 || m_st == 5)));
      chk("R6 pwr_good", pwr_good, ok && m_st == 4 && m_pg >= DONE && in_window);
      chk("R9 shutdown", shutdown, ok && m_st == 6);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1 reset state", state_dbg, 0);
    chk("R1 reset ss", ss_mv, 0);
    rst_n = 1;
    step(2);
    chk("R1 held off by uvlo", state_dbg, 0);
    // start with window closed: soft-start must stall and saturate
    uvlo = 0; en = 1;
    step(1);
    chk("R2 reset entered", state_dbg, 1);
    chk("R2 bias on", bias_en, 1);
    ilim = 1;  // ignored before clock-enable
    step(RC);
    chk("R2 detect entered", state_dbg, 2);
    step(PC);
    chk("R2 softstart entered", state_dbg, 3);
    chk("R7 fault ignored in softstart", state_dbg, 3);
    ilim = 0;
    step(70);
    chk("R4 waits for window", state_dbg, 3);
    chk("R3 ss saturates", ss_mv, CLAMP);
    chk("R3 pgd held", pgd_mv, 0);
    in_window = 1;
    step(1);
    chk("R4 active", state_dbg, 4);
    chk("R4 clk_en_n low", clk_en_n, 0);
    step(35);
    chk("R5 pgd done", pgd_mv, CLAMP);
    chk("R6 power good", pwr_good, 1);
    in_window = 0; #1;
    chk("R6 window drop", pwr_good, 0);
    in_window = 1;
    // recoverable overload
    ilim = 1;
    step(10);
    chk("R7 discharging", state_dbg, 5);
    chk("R7 ss fell", ss_mv, CLAMP - 9 * DN);
    chk("R7 pgd held", pgd_mv, CLAMP);
    ilim = 0;
    step(1);
    chk("R8 recovered", state_dbg, 4);
    step(10);
    chk("R8 ss back at clamp", ss_mv, CLAMP);
    // lasting fault: latch
    pg_fault = 1;
    step(60);
    chk("R9 latched", state_dbg, 6);
    chk("R9 shutdown", shutdown, 1);
    chk("R9 ramps cleared", ss_mv, 0);
    pg_fault = 0; ilim = 1;
    step(5);
    chk("R10 latch holds", state_dbg, 6);
    ilim = 0;
    en = 0;
    step(1);
    chk("R10 enable release", state_dbg, 0);
    en = 1;
    step(1);
    chk("R10 restart", state_dbg, 1);
    step(RC + PC + 40);
    chk("R4 second start", state_dbg, 4);
    ilim = 1;
    step(60);
    chk("R9 latched again", state_dbg, 6);
    uvlo = 1;
    step(1);
    chk("R10 uvlo release", state_dbg, 0);
    chk("R1 ss zero", ss_mv, 0);
    uvlo = 0; ilim = 0;
    step(RC + PC + 40);
    chk("R4 third start", state_dbg, 4);
    uvlo = 1; #1;
    chk("R1 immediate clk_en_n", clk_en_n, 1);
    step(1);
    chk("R1 pgd cleared", pgd_mv, 0);
    step(2);
    finish_run();
  end
endmodule